// File: doc/BRIEF.md
# Write-Back Write-Allocate Data Cache

This block is a tiny fully associative data cache that sits between a processor's byte-wide load/store port and a memory that moves whole blocks. The default build holds two lines of two bytes each and takes a 5-bit byte address. The upper four address bits are the block tag, and the lowest bit selects the byte within the block. Each line keeps a valid flag, a dirty flag, its tag and its block data.

Stores change only the cached copy and mark the line dirty. Memory is written only when a dirty line is chosen for eviction, and then the whole block is written back before the replacement block is read. Every miss allocates a line, whether it is a load or a store. A store miss fetches the block first and then merges the new byte into it. The replacement choice takes an invalid line first and otherwise takes the least recently used line. Two counters track hits and misses.

The processor raises a request and holds it until a one-cycle completion pulse. The memory side has separate block-read and block-write channels, and each one holds its request until it sees an acknowledge.

Top module: `cwb_cache`

## Requirements
- R1: After reset every line is invalid and clean, the hit and miss counters read zero, no memory request is raised, and the recency order puts line 0 as most recent.
- R2: A load whose tag matches a valid line returns that byte on `cpu_rdata` during the `cpu_done` pulse, raises no memory request and adds one to `hit_cnt`.
- R3: A store that hits writes its byte into the line, marks the line dirty and sends nothing to memory. `cpu_rdata` returns the byte's value from before the store.
- R4: A miss adds one to `miss_cnt` and reads the whole block at `cpu_addr[4:1]` through the read channel. On a load miss the line ends valid and clean, and the requested byte is returned.
- R5: A store miss first fetches the block, then merges the store byte into it, and leaves the line valid and dirty.
- R6: The victim is the lowest-indexed invalid line if one exists, and otherwise the least recently used line. Both hits and refills make the line touched the most recent.
- R7: Evicting a clean line raises no write request.
- R8: Evicting a dirty line first writes the full block with the victim's tag through the write channel. Only after that write is acknowledged does the read request appear.
- R9: On both block buses, byte offset 0 is bits [7:0] and offset 1 is bits [15:8].
- R10: `cpu_done` is high for exactly one cycle per access. Each memory request holds its address until it is acknowledged.
- R11: No two valid lines ever hold the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 5 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Loaded byte (prior value on a store) |
| mem_rd_req | output | 1 | Block read request |
| mem_rd_blk | output | 4 | Block number to read |
| mem_rd_ack | input | 1 | Read acknowledge, data valid |
| mem_rd_data | input | 16 | Block read data |
| mem_wr_req | output | 1 | Block write request |
| mem_wr_blk | output | 4 | Block number to write |
| mem_wr_data | output | 16 | Block write data |
| mem_wr_ack | input | 1 | Write acknowledge |
| hit_cnt | output | 16 | Hit count |
| miss_cnt | output | 16 | Miss count |

## Verification
Two functions can fall in the same clock edge. One is the refill landing in a line. The other is the store merge that follows a store miss, which marks that line dirty in the same cycle the fresh block arrives clean. The bench provokes this by aiming store misses at dirty victims, including stores to a block that was just written back, and it varies the memory latency from zero to three cycles. A bench model of lines, recency and backing memory judges each result: the byte read back later, the payload of every write-back, and a final comparison of the whole memory image.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } cwb_state_t;
endpackage

// File: rtl/cwb_match.sv
module cwb_match #(
  parameter int LINES  = 2,
  parameter int TAG_W  = 4,
  parameter int LIDX_W = 1
) (
  input  logic [LINES-1:0]       line_v,
  input  logic [LINES*TAG_W-1:0] line_tags,
  input  logic [TAG_W-1:0]       look_tag,
  output logic [LINES-1:0]       hit_vec,
  output logic                   any_hit,
  output logic [LIDX_W-1:0]      hit_idx
);
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign hit_vec[i] = line_v[i] && (line_tags[i*TAG_W +: TAG_W] == look_tag);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = LIDX_W'(i);
    end
  end
endmodule

// File: rtl/cwb_lru.sv
module cwb_lru #(
  parameter int LINES  = 2,
  parameter int LIDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  line_v,
  input  logic              touch,
  input  logic [LIDX_W-1:0] touch_idx,
  output logic [LIDX_W-1:0] victim_idx
);
  // age 0 = most recent, LINES-1 = least recent; ages stay a permutation
  logic [LIDX_W-1:0] age [LINES];
  logic [LINES-1:0]  oldest_vec;
  logic              free_found;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age[i] <= LIDX_W'(i);
    end else if (touch) begin
      for (int i = 0; i < LINES; i++) begin
        if (LIDX_W'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_old
    assign oldest_vec[i] = (age[i] == LIDX_W'(LINES - 1));
  end

  always_comb begin
    victim_idx = '0;
    free_found = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (!free_found && !line_v[i]) begin
        victim_idx = LIDX_W'(i);
        free_found = 1'b1;
      end
    end
    if (!free_found) begin
      for (int i = 0; i < LINES; i++) begin
        if (oldest_vec[i]) victim_idx = LIDX_W'(i);
      end
    end
  end

  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);
endmodule

// File: rtl/cwb_cache.sv
module cwb_cache
  import cwb_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int BLK_ITEMS = 2,
  parameter int LINES     = 2,
  parameter int CNT_W     = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cpu_req,
  input  logic                              cpu_we,
  input  logic [ADDR_W-1:0]                 cpu_addr,
  input  logic [DATA_W-1:0]                 cpu_wdata,
  output logic                              cpu_done,
  output logic [DATA_W-1:0]                 cpu_rdata,
  output logic                              mem_rd_req,
  output logic [ADDR_W-$clog2(BLK_ITEMS)-1:0] mem_rd_blk,
  input  logic                              mem_rd_ack,
  input  logic [DATA_W*BLK_ITEMS-1:0]       mem_rd_data,
  output logic                              mem_wr_req,
  output logic [ADDR_W-$clog2(BLK_ITEMS)-1:0] mem_wr_blk,
  output logic [DATA_W*BLK_ITEMS-1:0]       mem_wr_data,
  input  logic                              mem_wr_ack,
  output logic [CNT_W-1:0]                  hit_cnt,
  output logic [CNT_W-1:0]                  miss_cnt
);
  localparam int OFF_W  = $clog2(BLK_ITEMS);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int BLK_W  = DATA_W * BLK_ITEMS;
  localparam int LIDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] addr_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] item_get(input logic [BLK_W-1:0] blk,
                                                 input logic [OFF_W-1:0] off);
    return blk[off*DATA_W +: DATA_W];
  endfunction

  function automatic logic [BLK_W-1:0] item_put(input logic [BLK_W-1:0] blk,
                                                input logic [OFF_W-1:0] off,
                                                input logic [DATA_W-1:0] val);
    logic [BLK_W-1:0] r;
    r = blk;
    r[off*DATA_W +: DATA_W] = val;
    return r;
  endfunction

  cwb_state_t            state;
  logic [LINES-1:0]      v_q, d_q;
  logic [TAG_W-1:0]      tag_q  [LINES];
  logic [BLK_W-1:0]      data_q [LINES];
  logic [LINES*TAG_W-1:0] tags_flat;
  logic                  rq_we;
  logic [ADDR_W-1:0]     rq_addr;
  logic [DATA_W-1:0]     rq_wdata;
  logic [LIDX_W-1:0]     vic_q;

  logic [LINES-1:0]      hit_vec;
  logic                  any_hit;
  logic [LIDX_W-1:0]     hit_idx;
  logic [LIDX_W-1:0]     victim_idx;

  // named internal events
  logic lookup_hit, lookup_miss, wb_done, fill_done, lru_touch;
  logic [LIDX_W-1:0] lru_idx;

  for (genvar i = 0; i < LINES; i++) begin : g_flat
    assign tags_flat[i*TAG_W +: TAG_W] = tag_q[i];
  end

  cwb_match #(.LINES(LINES), .TAG_W(TAG_W), .LIDX_W(LIDX_W)) u_match (
    .line_v(v_q), .line_tags(tags_flat), .look_tag(addr_tag(rq_addr)),
    .hit_vec(hit_vec), .any_hit(any_hit), .hit_idx(hit_idx)
  );

  assign lookup_hit  = (state == ST_LOOKUP) && any_hit;
  assign lookup_miss = (state == ST_LOOKUP) && !any_hit;
  assign wb_done     = (state == ST_WRITEBACK) && mem_wr_ack;
  assign fill_done   = (state == ST_REFILL) && mem_rd_ack;
  assign lru_touch   = lookup_hit || fill_done;
  assign lru_idx     = lookup_hit ? hit_idx : vic_q;

  cwb_lru #(.LINES(LINES), .LIDX_W(LIDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n), .line_v(v_q),
    .touch(lru_touch), .touch_idx(lru_idx), .victim_idx(victim_idx)
  );

  assign cpu_done    = (state == ST_RESPOND);
  assign mem_wr_req  = (state == ST_WRITEBACK);
  assign mem_wr_blk  = tag_q[vic_q];
  assign mem_wr_data = data_q[vic_q];
  assign mem_rd_req  = (state == ST_REFILL);
  assign mem_rd_blk  = addr_tag(rq_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      v_q       <= '0;
      d_q       <= '0;
      hit_cnt   <= '0;
      miss_cnt  <= '0;
      cpu_rdata <= '0;
      vic_q     <= '0;
      rq_we     <= 1'b0;
      rq_addr   <= '0;
      rq_wdata  <= '0;
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      unique case (state)
        ST_IDLE: if (cpu_req) begin
          rq_we    <= cpu_we;
          rq_addr  <= cpu_addr;
          rq_wdata <= cpu_wdata;
          state    <= ST_LOOKUP;
        end
        ST_LOOKUP: if (any_hit) begin
          hit_cnt   <= hit_cnt + 1'b1;
          cpu_rdata <= item_get(data_q[hit_idx], addr_off(rq_addr));
          if (rq_we) begin
            data_q[hit_idx] <= item_put(data_q[hit_idx], addr_off(rq_addr), rq_wdata);
            d_q[hit_idx]    <= 1'b1;
          end
          state <= ST_RESPOND;
        end else begin
          miss_cnt <= miss_cnt + 1'b1;
          vic_q    <= victim_idx;
          if (v_q[victim_idx] && d_q[victim_idx]) begin
            state <= ST_WRITEBACK;
          end else begin
            v_q[victim_idx] <= 1'b0;
            state           <= ST_REFILL;
          end
        end
        ST_WRITEBACK: if (mem_wr_ack) begin
          v_q[vic_q] <= 1'b0;
          d_q[vic_q] <= 1'b0;
          state      <= ST_REFILL;
        end
        ST_REFILL: if (mem_rd_ack) begin
          tag_q[vic_q]  <= addr_tag(rq_addr);
          v_q[vic_q]    <= 1'b1;
          d_q[vic_q]    <= rq_we;
          data_q[vic_q] <= rq_we ? item_put(mem_rd_data, addr_off(rq_addr), rq_wdata)
                                 : mem_rd_data;
          cpu_rdata     <= item_get(mem_rd_data, addr_off(rq_addr));
          state         <= ST_RESPOND;
        end
        ST_RESPOND: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> !mem_rd_req && !mem_wr_req && cpu_done);

  assert_store_hit_dirty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_hit && rq_we) |=> |(d_q & $past(hit_vec)));

  assert_load_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && !rq_we) |=> v_q[vic_q] && !d_q[vic_q] && cpu_done);

  assert_store_fill_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && rq_we) |=> v_q[vic_q] && d_q[vic_q]);

  assert_clean_skip_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_miss && !(v_q[victim_idx] && d_q[victim_idx])) |=> mem_rd_req && !mem_wr_req);

  assert_wb_only_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> v_q[vic_q] && d_q[vic_q]);

  assert_wb_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_done |=> mem_rd_req && !v_q[vic_q]);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> mem_rd_req && $stable(mem_rd_blk));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_ack) |=> mem_wr_req && $stable(mem_wr_blk) && $stable(mem_wr_data));

  assert_unique_tags_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/cwb_cache_tb.sv
module cwb_cache_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [4:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_done;
  logic [7:0]  cpu_rdata;
  logic        mem_rd_req, mem_wr_req;
  logic [3:0]  mem_rd_blk, mem_wr_blk;
  logic        mem_rd_ack = 1'b0, mem_wr_ack = 1'b0;
  logic [15:0] mem_rd_data = '0;
  logic [15:0] mem_wr_data;
  logic [15:0] hit_cnt, miss_cnt;

  cwb_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req), .mem_rd_blk(mem_rd_blk),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_wr_req(mem_wr_req),
    .mem_wr_blk(mem_wr_blk), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .hit_cnt(hit_cnt), .miss_cnt(miss_cnt)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, order_bad = 0;
  int rd_wait = 0, wr_wait = 0, lat_sel = 0;
  logic [3:0]  last_wr_blk;
  logic [15:0] last_wr_data;

  logic [7:0]  mem  [32];   // memory seen through the block ports
  logic [7:0]  mmem [32];   // model of what memory should hold
  logic [7:0]  gold [32];   // what the processor should read
  bit          mv [2], md [2];
  logic [3:0]  mt [2];
  logic [15:0] mblk [2];
  int          mage [2];
  int          exp_hits = 0, exp_miss = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory responder: 0..3 cycle latency, block byte 0 in bits [7:0]
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rd_ack = 1'b0;
      mem_wr_ack = 1'b0;
    end else begin
      if (mem_rd_ack) mem_rd_ack = 1'b0;
      else if (mem_rd_req) begin
        if (rd_wait == 0) begin
          mem_rd_ack  = 1'b1;
          mem_rd_data = {mem[{mem_rd_blk, 1'b1}], mem[{mem_rd_blk, 1'b0}]};
          rd_cnt++;
          if (mem_wr_req) order_bad++;
          lat_sel = (lat_sel + 1) % 4;
          rd_wait = lat_sel;
        end else rd_wait--;
      end
      if (mem_wr_ack) mem_wr_ack = 1'b0;
      else if (mem_wr_req) begin
        if (wr_wait == 0) begin
          mem_wr_ack = 1'b1;
          mem[{mem_wr_blk, 1'b0}] = mem_wr_data[7:0];
          mem[{mem_wr_blk, 1'b1}] = mem_wr_data[15:8];
          last_wr_blk  = mem_wr_blk;
          last_wr_data = mem_wr_data;
          wr_cnt++;
          lat_sel = (lat_sel + 3) % 4;
          wr_wait = lat_sel;
        end else wr_wait--;
      end
    end
  end

  task automatic model_touch(input int k);
    int old;
    old = mage[k];
    for (int i = 0; i < 2; i++) begin
      if (i == k) mage[i] = 0;
      else if (mage[i] < old) mage[i]++;
    end
  endtask

  task automatic do_op(input bit we, input logic [4:0] addr, input logic [7:0] wd);
    bit hit, wb;
    int idx, wd_cnt;
    logic [3:0]  tag, wb_blk;
    logic [15:0] wb_data;
    logic [7:0]  prior;
    int rd0, wr0;
    tag = addr[4:1];
    hit = 0; idx = 0; wb = 0; wb_blk = '0; wb_data = '0;
    for (int i = 1; i >= 0; i--) if (mv[i] && mt[i] == tag) begin hit = 1; idx = i; end
    if (hit) exp_hits++;
    else begin
      exp_miss++;
      if (!mv[0]) idx = 0;
      else if (!mv[1]) idx = 1;
      else idx = (mage[0] == 1) ? 0 : 1;
      if (mv[idx] && md[idx]) begin
        wb = 1; wb_blk = mt[idx]; wb_data = mblk[idx];
        mmem[{mt[idx], 1'b0}] = mblk[idx][7:0];
        mmem[{mt[idx], 1'b1}] = mblk[idx][15:8];
      end
      mv[idx] = 1; md[idx] = 0; mt[idx] = tag;
      mblk[idx] = {mmem[{tag, 1'b1}], mmem[{tag, 1'b0}]};
    end
    if (we) begin
      md[idx] = 1;
      if (addr[0]) mblk[idx][15:8] = wd; else mblk[idx][7:0] = wd;
    end
    model_touch(idx);
    prior = gold[addr];
    if (we) gold[addr] = wd;

    rd0 = rd_cnt; wr0 = wr_cnt;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    wd_cnt = 0;
    do begin
      @(negedge clk);
      wd_cnt++;
    end while (!cpu_done && wd_cnt < 200);
    chk(cpu_done, "R10 completion timeout", wd_cnt, 0);
    if (hit) chk(cpu_rdata == prior, we ? "R3 store-hit prior byte" : "R2 load-hit byte", cpu_rdata, prior);
    else chk(cpu_rdata == prior, we ? "R5 store-miss prior byte" : "R4 R9 load-miss byte", cpu_rdata, prior);
    chk(hit_cnt == 16'(exp_hits), "R2 R6 R11 hit count", hit_cnt, exp_hits);
    chk(miss_cnt == 16'(exp_miss), "R4 R6 miss count", miss_cnt, exp_miss);
    chk(rd_cnt - rd0 == (hit ? 0 : 1), hit ? "R2 no read on hit" : "R4 one block read", rd_cnt - rd0, hit ? 0 : 1);
    chk(wr_cnt - wr0 == (wb ? 1 : 0), wb ? "R8 dirty write-back" : "R3 R7 no memory write", wr_cnt - wr0, wb ? 1 : 0);
    if (wb) begin
      chk(last_wr_blk == wb_blk, "R8 write-back tag", last_wr_blk, wb_blk);
      chk(last_wr_data == wb_data, "R8 R9 write-back data", last_wr_data, wb_data);
    end
    cpu_req = 1'b0;
    @(negedge clk);
    chk(!cpu_done, "R10 done single cycle", cpu_done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] lcg;
    for (int i = 0; i < 32; i++) begin
      mem[i] = 8'(i * 37 + 11); mmem[i] = mem[i]; gold[i] = mem[i];
    end
    for (int i = 0; i < 2; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; mblk[i] = '0; mage[i] = i; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hit_cnt == 0, "R1 hit count reset", hit_cnt, 0);
    chk(miss_cnt == 0, "R1 miss count reset", miss_cnt, 0);
    chk(!mem_rd_req && !mem_wr_req, "R1 no memory request", {mem_rd_req, mem_wr_req}, 0);
    chk(!cpu_done, "R1 done low", cpu_done, 0);

    // short program: loads, stores, dirty eviction and store to evicted block
    do_op(0, 5'd1, 8'h00);  do_op(0, 5'd7, 8'h00);
    do_op(1, 5'd0, 8'hA1);  do_op(1, 5'd5, 8'hB2);
    do_op(0, 5'd10, 8'h00); do_op(1, 5'd5, 8'hC3);
    do_op(1, 5'd10, 8'hD4);

    // R6 recency: touch block 0, then a new block must evict the other line
    do_op(0, 5'd0, 8'h00); do_op(0, 5'd2, 8'h00); do_op(0, 5'd1, 8'h00);
    do_op(0, 5'd4, 8'h00);
    do_op(0, 5'd0, 8'h00);
    chk(hit_cnt == 16'(exp_hits), "R6 LRU kept recent line", hit_cnt, exp_hits);

    // load sweep over every address
    for (int a = 0; a < 32; a++) do_op(0, 5'(a), 8'h00);
    // store then reload each address (R3 R5 merge)
    for (int a = 0; a < 32; a++) begin
      do_op(1, 5'(a), 8'(a ^ 8'h5A));
      do_op(0, 5'(a ^ 5'd1), 8'h00);
      do_op(0, 5'(a), 8'h00);
    end
    // mixed pseudo-random traffic with a narrow address spread
    lcg = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      do_op(lcg[20], {lcg[27:26], lcg[17], lcg[24:23]} & ((n % 3 == 0) ? 5'h1F : 5'h07), lcg[15:8]);
    end
    // flush: two fresh clean blocks evict whatever is dirty
    do_op(0, 5'd30, 8'h00); do_op(0, 5'd28, 8'h00);
    do_op(0, 5'd0, 8'h00);  do_op(0, 5'd2, 8'h00);
    for (int a = 0; a < 32; a++)
      chk(mem[a] == mmem[a], "R8 memory image", mem[a], mmem[a]);
    chk(order_bad == 0, "R8 write before read", order_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule